// File: doc/BRIEF.md
# Byte-Stream Command Framer for a Power Controller

This block sits between a host-side byte channel and the command handling of a small power-management controller. The host writes a transaction as a stream of bytes: an opcode, then its arguments. A lookup function maps each opcode to two framing rules, one for the request and one for the reply. Each rule is either a fixed byte count or "variable". A variable request carries a count byte right after the opcode. A variable reply is sent as a count byte followed by that many bytes.

Once the request is complete, the block spends one cycle executing the opcode. The executor can:
- load or read a 32-bit seconds counter;
- write or read an 8-bit interrupt mask;
- read and clear the pending interrupt bits;
- echo the arguments back.

It then streams the reply. Pending interrupt bits are set by event pulses and by an internal one-second tick. A level interrupt output is high while any pending bit is also enabled in the mask.

Both byte channels use valid/ready. A byte moves on a rising edge where valid and ready are both high.

The request side is ready only in the idle and argument-collection phases. It refuses bytes from the cycle after the request completes until the last reply byte has been taken.

Once the reply side raises valid, it holds the byte stable until ready is seen. Ready may be withheld for any number of cycles without loss.

The argument store holds `BUF_DEPTH` bytes (default 128, at most 255).

Top module: `pmf_cmd_engine`

## Requirements
- R1: After reset, the request side is ready, no reply byte is offered, the interrupt output is low, and both the mask and the pending bits read back as 0x00.
- R2: The request-side ready and reply-side valid are never high together. While the reply side is stalled, valid stays high and the data byte does not change.
- R3: Opcode 0x30 takes 4 argument bytes, most significant first, loads them into the seconds counter, and sends no reply. Opcode 0x38 takes no arguments and replies with the 4 counter bytes, most significant first.
- R4: Opcode 0x20 has a variable request and a variable reply. The byte after the opcode is a count N, then N arguments follow. The reply is a count byte equal to min(N, BUF_DEPTH), then the first min(N, BUF_DEPTH) arguments in order. Arguments past BUF_DEPTH are accepted and dropped.
- R5: Opcode 0x20 with N = 0 takes no further bytes and replies with the single byte 0x00.
- R6: An opcode that is not listed takes a variable request (a count byte, then that many bytes), sends no reply, and changes neither the mask nor the pending bits.
- R7: Opcode 0x70 takes one argument and writes it to the interrupt mask. Opcode 0x74 takes no arguments and replies with the mask byte.
- R8: Opcode 0x78 takes no arguments and replies with the pending bits. Every bit it returns is cleared.
- R9: An event pulse sets pending bits 0x40 (environment), 0x20 (battery), 0x10 (serial-bus data), 0x08 (buttons) and 0x04 (card eject). Pulse bits 0x02 and 0x01 are ignored.
- R10: The interrupt output is high exactly when (pending AND mask) is nonzero. It follows a change in either one a cycle later.
- R11: Every CLK_HZ cycles the seconds counter advances by one and pending bit 0x80 is set. Executing 0x30 restarts this interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Request byte valid |
| cmd_ready_o | output | 1 | Request byte accepted when high with valid |
| cmd_data_i | input | 8 | Request byte |
| rsp_valid_o | output | 1 | Reply byte valid |
| rsp_ready_i | input | 1 | Host accepts reply byte |
| rsp_data_o | output | 8 | Reply byte |
| evt_pulse_i | input | 8 | One-cycle event pulses, one bit per source |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets these corner cases:
- A variable request of 130 bytes. A framer without clamping would overrun its store or report the wrong count; one that stopped early would treat the dropped tail as new opcodes.
- A zero-count echo. A framer that waited for a first argument would hang, and one that skipped the count byte would send nothing.
- An unlisted opcode followed by a real one. This exposes a framer that loses byte alignment.
- Reads of the pending bits after masked events, ignored pulse bits and a tick. A design that cleared too much, kept bits set after reading, or ignored the mask on the interrupt output would show it here.
- Random reply-side stalls. These catch a reply byte that changes or is skipped under back-pressure.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ARGS, ST_EXEC, ST_REPLY} fsm_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_WORD, SRC_BYTE, SRC_ARGS} rsp_src_e;

  // framing rule pair: *_var set means a count byte travels on the wire
  typedef struct packed {
    logic       arg_var;
    logic [7:0] arg_n;
    logic       rsp_var;
    logic [7:0] rsp_n;
  } frame_t;

  localparam logic [7:0] OP_ECHO     = 8'h20;
  localparam logic [7:0] OP_SET_CLK  = 8'h30;
  localparam logic [7:0] OP_GET_CLK  = 8'h38;
  localparam logic [7:0] OP_SET_MASK = 8'h70;
  localparam logic [7:0] OP_GET_MASK = 8'h74;
  localparam logic [7:0] OP_GET_PEND = 8'h78;

  localparam logic [7:0] EVT_BITS = 8'h7C;
  localparam logic [7:0] TICK_BIT = 8'h80;

  function automatic frame_t frame_of(input logic [7:0] op);
    frame_t f;
    case (op)
      OP_ECHO:     f = '{arg_var: 1'b1, arg_n: 8'd0, rsp_var: 1'b1, rsp_n: 8'd0};
      OP_SET_CLK:  f = '{arg_var: 1'b0, arg_n: 8'd4, rsp_var: 1'b0, rsp_n: 8'd0};
      OP_GET_CLK:  f = '{arg_var: 1'b0, arg_n: 8'd0, rsp_var: 1'b0, rsp_n: 8'd4};
      OP_SET_MASK: f = '{arg_var: 1'b0, arg_n: 8'd1, rsp_var: 1'b0, rsp_n: 8'd0};
      OP_GET_MASK: f = '{arg_var: 1'b0, arg_n: 8'd0, rsp_var: 1'b0, rsp_n: 8'd1};
      OP_GET_PEND: f = '{arg_var: 1'b0, arg_n: 8'd0, rsp_var: 1'b0, rsp_n: 8'd1};
      default:     f = '{arg_var: 1'b1, arg_n: 8'd0, rsp_var: 1'b0, rsp_n: 8'd0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pmf_arg_buffer.sv
module pmf_arg_buffer #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [31:0]   head_word_o
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == AW'(i))) mem[i] <= wr_data_i;
    end
  end

  assign rd_data_o   = mem[rd_idx_i];
  assign head_word_o = {mem[0], mem[1], mem[2], mem[3]};
endmodule

// File: rtl/pmf_second_timer.sv
module pmf_second_timer #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] load_val_i,
  output logic [31:0] seconds_o,
  output logic        tick_o
);
  localparam int unsigned CNT_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      sec_q;

  assign tick_o    = (cnt_q == LAST) && !load_i;
  assign seconds_o = sec_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sec_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      sec_q <= load_val_i;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      sec_q <= sec_q + 32'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmf_irq_unit.sv
module pmf_irq_unit
  import pmf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] evt_i,
  input  logic       tick_i,
  input  logic       clr_en_i,
  input  logic [7:0] clr_bits_i,
  input  logic       mask_we_i,
  input  logic [7:0] mask_d_i,
  output logic [7:0] pend_o,
  output logic [7:0] mask_o,
  output logic       irq_o
);
  logic [7:0] pend_q, mask_q, set_bits, keep_bits;

  assign set_bits  = (evt_i & EVT_BITS) | (tick_i ? TICK_BIT : 8'h00);
  assign keep_bits = clr_en_i ? ~clr_bits_i : 8'hFF;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & keep_bits) | set_bits;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & mask_q);
endmodule

// File: rtl/pmf_cmd_engine.sv
module pmf_cmd_engine
  import pmf_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BUF_DEPTH = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [7:0] cmd_data_i,
  output logic       rsp_valid_o,
  input  logic       rsp_ready_i,
  output logic [7:0] rsp_data_o,
  input  logic [7:0] evt_pulse_i,
  output logic       irq_o
);
  localparam int unsigned IDX_W = $clog2(BUF_DEPTH + 1);
  localparam int unsigned AW    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [IDX_W-1:0] FULL = IDX_W'(BUF_DEPTH);

  fsm_e             state_q;
  logic [7:0]       op_q;
  logic             rsp_var_q;
  logic [7:0]       rsp_n_q;
  logic             need_len_q;
  logic [7:0]       remain_q;
  logic [IDX_W-1:0] kept_q;
  logic             hdr_q;
  logic [IDX_W-1:0] rsp_len_q;
  logic [IDX_W-1:0] rsp_pos_q;
  logic [31:0]      snap_q;
  rsp_src_e         src_q;

  frame_t      fr_in;
  logic        cmd_fire, rsp_fire, in_exec, buf_we;
  logic [7:0]  buf_rd;
  logic [31:0] head_word, seconds;
  logic        tick;
  logic [7:0]  irq_pend, irq_mask;
  logic [31:0] snap_d;
  rsp_src_e    src_d;

  assign fr_in       = frame_of(cmd_data_i);
  assign cmd_ready_o = (state_q == ST_IDLE) || (state_q == ST_ARGS);
  assign rsp_valid_o = (state_q == ST_REPLY);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign rsp_fire    = rsp_valid_o && rsp_ready_i;
  assign in_exec     = (state_q == ST_EXEC);
  assign buf_we      = cmd_fire && (state_q == ST_ARGS) && !need_len_q && (kept_q < FULL);

  pmf_arg_buffer #(.DEPTH(BUF_DEPTH)) u_args (
    .clk_i      (clk_i),
    .wr_en_i    (buf_we),
    .wr_idx_i   (kept_q[AW-1:0]),
    .wr_data_i  (cmd_data_i),
    .rd_idx_i   (rsp_pos_q[AW-1:0]),
    .rd_data_o  (buf_rd),
    .head_word_o(head_word)
  );

  pmf_second_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (in_exec && (op_q == OP_SET_CLK)),
    .load_val_i(head_word),
    .seconds_o (seconds),
    .tick_o    (tick)
  );

  pmf_irq_unit u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_pulse_i),
    .tick_i    (tick),
    .clr_en_i  (in_exec && (op_q == OP_GET_PEND)),
    .clr_bits_i(irq_pend),
    .mask_we_i (in_exec && (op_q == OP_SET_MASK)),
    .mask_d_i  (head_word[31:24]),
    .pend_o    (irq_pend),
    .mask_o    (irq_mask),
    .irq_o     (irq_o)
  );

  // executor: pick what the reply streams from
  always_comb begin
    snap_d = '0;
    src_d  = SRC_NONE;
    case (op_q)
      OP_GET_CLK:  begin snap_d = seconds;          src_d = SRC_WORD; end
      OP_GET_MASK: begin snap_d = {24'd0, irq_mask}; src_d = SRC_BYTE; end
      OP_GET_PEND: begin snap_d = {24'd0, irq_pend}; src_d = SRC_BYTE; end
      OP_ECHO:     src_d = SRC_ARGS;
      default:     src_d = SRC_NONE;
    endcase
  end

  always_comb begin
    if (hdr_q) begin
      rsp_data_o = rsp_len_q[7:0];
    end else begin
      case (src_q)
        SRC_WORD: begin
          case (rsp_pos_q[1:0])
            2'd0:    rsp_data_o = snap_q[31:24];
            2'd1:    rsp_data_o = snap_q[23:16];
            2'd2:    rsp_data_o = snap_q[15:8];
            default: rsp_data_o = snap_q[7:0];
          endcase
        end
        SRC_BYTE: rsp_data_o = snap_q[7:0];
        SRC_ARGS: rsp_data_o = buf_rd;
        default:  rsp_data_o = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      rsp_var_q  <= 1'b0;
      rsp_n_q    <= '0;
      need_len_q <= 1'b0;
      remain_q   <= '0;
      kept_q     <= '0;
      hdr_q      <= 1'b0;
      rsp_len_q  <= '0;
      rsp_pos_q  <= '0;
      snap_q     <= '0;
      src_q      <= SRC_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_fire) begin
          op_q       <= cmd_data_i;
          rsp_var_q  <= fr_in.rsp_var;
          rsp_n_q    <= fr_in.rsp_n;
          need_len_q <= fr_in.arg_var;
          remain_q   <= fr_in.arg_n;
          kept_q     <= '0;
          state_q    <= (fr_in.arg_var || (fr_in.arg_n != 8'd0)) ? ST_ARGS : ST_EXEC;
        end
        ST_ARGS: if (cmd_fire) begin
          if (need_len_q) begin
            need_len_q <= 1'b0;
            remain_q   <= cmd_data_i;
            if (cmd_data_i == 8'd0) state_q <= ST_EXEC;
          end else begin
            if (kept_q < FULL) kept_q <= kept_q + 1'b1;
            remain_q <= remain_q - 8'd1;
            if (remain_q == 8'd1) state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          rsp_pos_q <= '0;
          snap_q    <= snap_d;
          src_q     <= src_d;
          if (rsp_var_q) begin
            rsp_len_q <= (op_q == OP_ECHO) ? kept_q : '0;
            hdr_q     <= 1'b1;
            state_q   <= ST_REPLY;
          end else begin
            rsp_len_q <= IDX_W'(rsp_n_q);
            hdr_q     <= 1'b0;
            state_q   <= (rsp_n_q == 8'd0) ? ST_IDLE : ST_REPLY;
          end
        end
        default: if (rsp_fire) begin
          if (hdr_q) begin
            hdr_q <= 1'b0;
            if (rsp_len_q == '0) state_q <= ST_IDLE;
          end else begin
            rsp_pos_q <= rsp_pos_q + 1'b1;
            if (rsp_pos_q == rsp_len_q - 1'b1) state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pmf_cmd_engine_chk.sv
module pmf_cmd_engine_chk #(
  parameter int unsigned BUF_DEPTH = 128,
  parameter int unsigned IDX_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [7:0]       rsp_data_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] kept,
  input logic [7:0]       mask
);
  assert_half_duplex_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && rsp_valid_o));

  assert_stall_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  assert_reply_end_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rsp_valid_o) |-> cmd_ready_o);

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kept <= IDX_W'(BUF_DEPTH));

  assert_masked_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == 8'h00) |-> !irq_o);
endmodule

bind pmf_cmd_engine pmf_cmd_engine_chk #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_ready_o(cmd_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_data_o (rsp_data_o),
  .irq_o      (irq_o),
  .kept       (kept_q),
  .mask       (irq_mask)
);

// File: tb/pmf_cmd_engine_tb.sv
module pmf_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, rsp_valid, irq;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [7:0] evt = 8'h00;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string cur_tag = "R1";
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic stall_prev = 1'b0;
  logic [7:0] stall_data = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmf_cmd_engine #(.CLK_HZ(TB_HZ), .BUF_DEPTH(128)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .evt_pulse_i(evt), .irq_o(irq)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reply-side back-pressure
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  // monitor: pops the scoreboard on each reply handshake
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid && cmd_ready) chk(1'b0, "R2 ready during reply", 1, 0);
      if (stall_prev) chk(rsp_valid && (rsp_data == stall_data), "R2 stall hold", rsp_data, stall_data);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected reply byte"}, rsp_data, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rsp_data == e, cur_tag, rsp_data, e);
        end
      end
      stall_prev = rsp_valid && !rsp_ready;
      stall_data = rsp_data;
    end
  end

  task automatic put(input logic [7:0] b);
    cmd_data  = b;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] v);
    evt = v;
    @(negedge clk);
    evt = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_clock(input logic [31:0] v);
    put(8'h30); put(v[31:24]); put(v[23:16]); put(v[15:8]); put(v[7:0]);
    repeat (2) @(negedge clk);
  endtask

  task automatic read_one(input logic [7:0] op, input logic [7:0] e, input string tag);
    cur_tag = tag;
    exp_q.push_back(e);
    put(op);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready in reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no reply in reset", rsp_valid, 0);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_one(8'h74, 8'h00, "R1 mask after reset");
    read_one(8'h78, 8'h00, "R1 pending after reset");

    // R3 fixed framing both ways, under back-pressure
    bp_en = 1'b1;
    set_clock(32'h12345678);
    cur_tag = "R3 clock readback";
    exp_q.push_back(8'h12); exp_q.push_back(8'h34);
    exp_q.push_back(8'h56); exp_q.push_back(8'h78);
    put(8'h38);
    drain();

    // R4 short echo
    cur_tag = "R4 echo 5";
    exp_q.push_back(8'd5);
    for (int i = 0; i < 5; i++) exp_q.push_back(8'(8'hC0 + i));
    put(8'h20); put(8'd5);
    for (int i = 0; i < 5; i++) put(8'(8'hC0 + i));
    drain();

    // R4 clamp at 128
    cur_tag = "R4 echo clamp";
    exp_q.push_back(8'd128);
    for (int i = 0; i < 128; i++) exp_q.push_back(8'(i) ^ 8'h5A);
    put(8'h20); put(8'd130);
    for (int i = 0; i < 130; i++) put(8'(i) ^ 8'h5A);
    drain();

    // R5 zero-length echo
    cur_tag = "R5 empty echo";
    exp_q.push_back(8'h00);
    put(8'h20); put(8'h00);
    drain();
    bp_en = 1'b0;

    // R6 unlisted opcode: no reply, framing kept, no effect
    cur_tag = "R6 unlisted opcode";
    put(8'h55); put(8'd2); put(8'h70); put(8'h24);
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R6 back to idle", cmd_ready, 1);
    read_one(8'h74, 8'h00, "R6 mask untouched");
    cur_tag = "R6 aligned after";
    exp_q.push_back(8'd1); exp_q.push_back(8'h99);
    put(8'h20); put(8'd1); put(8'h99);
    drain();

    // interrupt block, started right after a prescaler restart
    set_clock(32'h0);
    put(8'h70); put(8'h24);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R10 nothing pending", irq, 0);
    read_one(8'h74, 8'h24, "R7 mask readback");
    pulse(8'h20);
    chk(irq == 1'b1, "R10 enabled bit raises irq", irq, 1);
    pulse(8'h08);
    read_one(8'h78, 8'h28, "R8 pending read");
    chk(irq == 1'b0, "R8 read clears, irq drops", irq, 0);
    pulse(8'h40);
    chk(irq == 1'b0, "R10 masked bit keeps irq low", irq, 0);
    read_one(8'h78, 8'h40, "R9 environment bit");
    pulse(8'h03);
    read_one(8'h78, 8'h00, "R9 low bits ignored");
    pulse(8'hFF);
    chk(irq == 1'b1, "R10 all events", irq, 1);
    read_one(8'h78, 8'h7C, "R9 all event bits");
    read_one(8'h78, 8'h00, "R8 cleared after read");

    // R11 tick
    set_clock(32'h000000FF);
    repeat (TB_HZ + 10) @(negedge clk);
    cur_tag = "R11 seconds advanced";
    exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    exp_q.push_back(8'h01); exp_q.push_back(8'h00);
    put(8'h38);
    drain();
    read_one(8'h78, 8'h80, "R11 tick bit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule